// File: doc/BRIEF.md
# Bus Trigger Match and Sequencer

This block is the trigger engine of an on-chip bus monitor. Each clock it compares a probed group of bus signals against up to two programmed patterns. It counts how many times a pattern occurs and can require a second pattern to appear after the first. When the condition is met, it raises a trigger indicator that a capture buffer can consume, or that can be routed to other logic or off chip.

The engine is started by a one-cycle arm strobe. A stage pattern uses a value, a care mask, a second value that bounds a range, per-bit rise and fall demands, a 3-bit compare mode and an occurrence target. Build parameters choose the following:

- the probe width;
- the occurrence-counter width, where zero means the first hit fires;
- one or two stages;
- whether the probe is one bus value or a bundle of unrelated control signals;
- whether the group is enabled at all.

Top module: `bus_trig_seq`

## Requirements
- R1: After reset, `stage_hit`, `trig_pulse` and `triggered` are 0. Nothing is matched or counted until `arm` has been sampled high.
- R2: Mode 0 is a masked equality: a stage hits when `(probe & mask) == (value & mask)`. A mask bit of 0 is a don't-care. Mode 7 behaves as mode 0.
- R3: In a single-bus build (`SINGLE_BUS=1`), the modes compare the masked probe against the masked value and limit as follows: 1 is not equal; 2 is greater than value; 3 is less than value; 4 is inside the inclusive range [value, limit]; 5 is outside that range. All compares are unsigned.
- R4: In a multi-signal build (`SINGLE_BUS=0`), modes 1 to 5 and 7 act as mode 0, and mode 6 still works.
- R5: Mode 6 checks each masked bit i separately:
  - if `rise[i]` is set, bit i needs a 0-to-1 change from the previous sample;
  - else if `fall[i]` is set, bit i needs a 1-to-0 change;
  - else bit i must equal `value[i]`.
  In the first cycle after `arm`, no bit that demands a change can match.
- R6: With `CNT_W>0`, the active stage completes on its N-th hit since arm, where N is its `target`. A target of 0 counts as 1. Hits need not be consecutive, and cycles without a hit are not counted.
- R7: With `CNT_W=0`, a stage completes on its first hit, whatever its target.
- R8: With `TWO_STAGE=1`, stage 1 hits are not counted until stage 0 has completed. Stage 1 counting starts in the cycle after stage 0 completes, and only stage 1 completing fires the trigger.
- R9: `trig_pulse` is high for exactly the one cycle after the hit that completes the final stage. `triggered` rises in the same cycle and stays high until the next `arm`. While `triggered` is high, `stage_hit` stays 0 and nothing is counted.
- R10: `arm` clears `triggered`, the counters and the sequence position, even while the engine is running or has already triggered.
- R11: With `GROUP_EN=0`, all compare settings are ignored: `stage_hit` is always 0 and the engine never triggers.
- R12: `stage_hit[i]` shows stage i's compare result in every cycle while armed and not triggered. In a single-stage build, `stage_hit[1]` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | One-cycle strobe that (re)starts the engine |
| probe | input | PROBE_W | Probed signal group |
| cfg_value | input | 2 x PROBE_W | Per-stage compare value, also the lower range bound |
| cfg_limit | input | 2 x PROBE_W | Per-stage upper range bound |
| cfg_mask | input | 2 x PROBE_W | Per-stage care mask |
| cfg_rise | input | 2 x PROBE_W | Per-stage per-bit rising-edge demand (mode 6) |
| cfg_fall | input | 2 x PROBE_W | Per-stage per-bit falling-edge demand (mode 6) |
| cfg_mode | input | 2 x 3 | Per-stage compare mode |
| cfg_target | input | 2 x TGT_W | Per-stage occurrence target, where TGT_W is max(CNT_W,1) |
| stage_hit | output | 2 | Per-stage match flag |
| trig_pulse | output | 1 | One-cycle trigger indicator |
| triggered | output | 1 | Sticky triggered flag |

## Verification
The assertions check, in every cycle, properties that need no knowledge of the configuration:
- the trigger pulse lasts one cycle and is backed by a final-stage hit in the previous cycle;
- the triggered flag stays high until arm and arm clears it;
- matching stops once triggered;
- an unused second stage and a disabled group stay silent;
- no edge-demanding mode 6 stage hits in the first cycle after arm.

Only the bench scenarios, which run a reference model of the compare modes and the counting sequence, can show the following: that each relational and edge mode picks the right cycles, that the N-th hit rather than an earlier one completes a stage, and that stage 1 is ignored before stage 0 finishes.

// File: rtl/bts_pkg.sv
package bts_pkg;
   typedef enum logic [2:0] {
      CM_EQ   = 3'd0,
      CM_NE   = 3'd1,
      CM_GT   = 3'd2,
      CM_LT   = 3'd3,
      CM_IN   = 3'd4,
      CM_OUT  = 3'd5,
      CM_EDGE = 3'd6,
      CM_RSVD = 3'd7
   } cmp_mode_e;

   localparam int unsigned STAGE_SLOTS = 2;
endpackage

// File: rtl/bts_compare.sv
module bts_compare
   import bts_pkg::*;
#(
   parameter int unsigned PROBE_W    = 8,
   parameter bit          SINGLE_BUS = 1'b1
) (
   input  logic [PROBE_W-1:0] probe,
   input  logic [PROBE_W-1:0] prev,
   input  logic               prev_ok,
   input  logic [PROBE_W-1:0] value,
   input  logic [PROBE_W-1:0] limit,
   input  logic [PROBE_W-1:0] mask,
   input  logic [PROBE_W-1:0] rise,
   input  logic [PROBE_W-1:0] fall,
   input  logic [2:0]         mode,
   output logic               hit
);
   logic [PROBE_W-1:0] mp, mv, ml, bit_ok;
   logic               eq_hit, edge_hit;
   cmp_mode_e          m;

   assign mp = probe & mask;
   assign mv = value & mask;
   assign ml = limit & mask;
   assign m  = cmp_mode_e'(mode);

   // per-bit qualifier for the edge-aware mode
   for (genvar i = 0; i < PROBE_W; i++) begin : g_bit
      always_comb begin
         if (!mask[i])
            bit_ok[i] = 1'b1;
         else if (rise[i])
            bit_ok[i] = prev_ok & ~prev[i] & probe[i];
         else if (fall[i])
            bit_ok[i] = prev_ok & prev[i] & ~probe[i];
         else
            bit_ok[i] = (probe[i] == value[i]);
      end
   end

   assign eq_hit   = (mp == mv);
   assign edge_hit = &bit_ok;

   if (SINGLE_BUS) begin : g_bus
      always_comb begin
         case (m)
            CM_NE:   hit = !eq_hit;
            CM_GT:   hit = (mp > mv);
            CM_LT:   hit = (mp < mv);
            CM_IN:   hit = (mp >= mv) && (mp <= ml);
            CM_OUT:  hit = !((mp >= mv) && (mp <= ml));
            CM_EDGE: hit = edge_hit;
            default: hit = eq_hit;
         endcase
      end
   end else begin : g_bundle
      logic unused_lim;
      assign unused_lim = ^ml;
      // relational codes make no sense on unrelated signals: fold to equality
      always_comb begin
         if (m == CM_EDGE) hit = edge_hit;
         else              hit = eq_hit;
      end
   end
endmodule

// File: rtl/bts_counter.sv
module bts_counter #(
   parameter int unsigned CNT_W = 3,
   localparam int unsigned TGT_W = (CNT_W == 0) ? 1 : CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [TGT_W-1:0] target,
   output logic             done
);
   if (CNT_W == 0) begin : g_first
      logic unused_in;
      assign unused_in = ^{clk, rst_n, clr, target};
      assign done = en;
   end else begin : g_count
      logic [CNT_W-1:0] cnt;
      logic [CNT_W:0]   cnt_next;

      assign cnt_next = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
      // target 0 is satisfied by the first hit, like target 1
      assign done = en && (cnt_next >= {1'b0, target});

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  cnt <= '0;
         else if (clr) cnt <= '0;
         else if (en)  cnt <= cnt_next[CNT_W-1:0];
      end
   end
endmodule

// File: rtl/bts_sequencer.sv
module bts_sequencer #(
   parameter bit TWO_STAGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic done0,
   input  logic done1,
   output logic running,
   output logic stage1_act,
   output logic trig_pulse,
   output logic triggered
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running    <= 1'b0;
         stage1_act <= 1'b0;
         trig_pulse <= 1'b0;
         triggered  <= 1'b0;
      end else if (arm) begin
         running    <= 1'b1;
         stage1_act <= 1'b0;
         trig_pulse <= 1'b0;
         triggered  <= 1'b0;
      end else begin
         trig_pulse <= 1'b0;
         if (running && !triggered) begin
            if (!stage1_act && done0) begin
               if (TWO_STAGE) begin
                  stage1_act <= 1'b1;
               end else begin
                  trig_pulse <= 1'b1;
                  triggered  <= 1'b1;
               end
            end else if (stage1_act && done1) begin
               trig_pulse <= 1'b1;
               triggered  <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/bus_trig_seq.sv
module bus_trig_seq
   import bts_pkg::*;
#(
   parameter int unsigned PROBE_W    = 8,
   parameter int unsigned CNT_W      = 3,
   parameter bit          TWO_STAGE  = 1'b1,
   parameter bit          SINGLE_BUS = 1'b1,
   parameter bit          GROUP_EN   = 1'b1,
   localparam int unsigned TGT_W     = (CNT_W == 0) ? 1 : CNT_W,
   localparam int unsigned NUM_ST    = TWO_STAGE ? 2 : 1
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                arm,
   input  logic [PROBE_W-1:0]                  probe,
   input  logic [STAGE_SLOTS-1:0][PROBE_W-1:0] cfg_value,
   input  logic [STAGE_SLOTS-1:0][PROBE_W-1:0] cfg_limit,
   input  logic [STAGE_SLOTS-1:0][PROBE_W-1:0] cfg_mask,
   input  logic [STAGE_SLOTS-1:0][PROBE_W-1:0] cfg_rise,
   input  logic [STAGE_SLOTS-1:0][PROBE_W-1:0] cfg_fall,
   input  logic [STAGE_SLOTS-1:0][2:0]         cfg_mode,
   input  logic [STAGE_SLOTS-1:0][TGT_W-1:0]   cfg_target,
   output logic [STAGE_SLOTS-1:0]              stage_hit,
   output logic                                trig_pulse,
   output logic                                triggered
);
   if (PROBE_W < 1 || PROBE_W > 1024) begin : g_bad_width
      $error("bus_trig_seq: PROBE_W out of range");
   end
   if (CNT_W > 24) begin : g_bad_cnt
      $error("bus_trig_seq: CNT_W out of range");
   end

   logic [PROBE_W-1:0]     prev_q;
   logic                   prev_ok_q;
   logic                   running, stage1_act, active;
   logic [STAGE_SLOTS-1:0] cmp_hit, cnt_en, done;

   // previous-sample history for edge compares; arm invalidates it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q    <= '0;
         prev_ok_q <= 1'b0;
      end else begin
         prev_q    <= probe;
         prev_ok_q <= !arm;
      end
   end

   assign active = GROUP_EN && running && !triggered;

   for (genvar s = 0; s < STAGE_SLOTS; s++) begin : g_stage
      if (s < NUM_ST) begin : g_used
         bts_compare #(
            .PROBE_W   (PROBE_W),
            .SINGLE_BUS(SINGLE_BUS)
         ) u_cmp (
            .probe  (probe),
            .prev   (prev_q),
            .prev_ok(prev_ok_q),
            .value  (cfg_value[s]),
            .limit  (cfg_limit[s]),
            .mask   (cfg_mask[s]),
            .rise   (cfg_rise[s]),
            .fall   (cfg_fall[s]),
            .mode   (cfg_mode[s]),
            .hit    (cmp_hit[s])
         );

         assign stage_hit[s] = active && cmp_hit[s];
         assign cnt_en[s]    = stage_hit[s] && ((s == 0) ? !stage1_act : stage1_act);

         bts_counter #(
            .CNT_W(CNT_W)
         ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (arm),
            .en    (cnt_en[s]),
            .target(cfg_target[s]),
            .done  (done[s])
         );
      end else begin : g_idle
         logic unused_cfg;
         assign unused_cfg = ^{cfg_value[s], cfg_limit[s], cfg_mask[s], cfg_rise[s],
                               cfg_fall[s], cfg_mode[s], cfg_target[s]};
         assign cmp_hit[s]   = 1'b0;
         assign stage_hit[s] = 1'b0;
         assign cnt_en[s]    = 1'b0;
         assign done[s]      = 1'b0;
      end
   end

   bts_sequencer #(
      .TWO_STAGE(TWO_STAGE)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm       (arm),
      .done0     (done[0]),
      .done1     (done[1]),
      .running   (running),
      .stage1_act(stage1_act),
      .trig_pulse(trig_pulse),
      .triggered (triggered)
   );
endmodule

// File: rtl/bts_checker.sv
module bts_checker
   import bts_pkg::*;
#(
   parameter int unsigned PROBE_W   = 8,
   parameter bit          TWO_STAGE = 1'b1,
   parameter bit          GROUP_EN  = 1'b1
) (
   input logic                                clk,
   input logic                                rst_n,
   input logic                                arm,
   input logic [STAGE_SLOTS-1:0][PROBE_W-1:0] cfg_mask,
   input logic [STAGE_SLOTS-1:0][PROBE_W-1:0] cfg_rise,
   input logic [STAGE_SLOTS-1:0][PROBE_W-1:0] cfg_fall,
   input logic [STAGE_SLOTS-1:0][2:0]         cfg_mode,
   input logic [STAGE_SLOTS-1:0]              stage_hit,
   input logic                                trig_pulse,
   input logic                                triggered
);
   localparam int unsigned LAST = TWO_STAGE ? 1 : 0;

   assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      trig_pulse |=> !trig_pulse);

   assert_pulse_has_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      trig_pulse |-> triggered);

   assert_pulse_after_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      trig_pulse |-> $past(stage_hit[LAST]));

   assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (triggered && !arm) |=> triggered);

   assert_quiet_when_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      triggered |-> (stage_hit == '0));

   assert_arm_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> (!triggered && !trig_pulse));

   assert_edge_first_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(arm) && cfg_mode[0] == CM_EDGE && |(cfg_mask[0] & (cfg_rise[0] | cfg_fall[0])))
      |-> !stage_hit[0]);

   if (!TWO_STAGE) begin : g_one
      assert_spare_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
         !stage_hit[1]);
   end

   if (!GROUP_EN) begin : g_off
      assert_group_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (stage_hit == '0) && !triggered);
   end
endmodule

bind bus_trig_seq bts_checker #(
   .PROBE_W  (PROBE_W),
   .TWO_STAGE(TWO_STAGE),
   .GROUP_EN (GROUP_EN)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .arm       (arm),
   .cfg_mask  (cfg_mask),
   .cfg_rise  (cfg_rise),
   .cfg_fall  (cfg_fall),
   .cfg_mode  (cfg_mode),
   .stage_hit (stage_hit),
   .trig_pulse(trig_pulse),
   .triggered (triggered)
);

// File: tb/tb_bus_trig_seq.sv
module tb_bus_trig_seq;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic            arm = 1'b0;
   logic [7:0]      probe = '0;
   logic [1:0][7:0] cv = '0, cl = '0, cm = '0, cr = '0, cf = '0;
   logic [1:0][2:0] cmode = '0, ctgt = '0;
   logic [1:0][0:0] tgt_one = '0;

   logic [1:0] hit_m, hit_1, hit_x, hit_o;
   logic tp_m, tr_m, tp_1, tr_1, tp_x, tr_x, tp_o, tr_o;

   int checks = 0;
   int errors = 0;

   bus_trig_seq #(.PROBE_W(8), .CNT_W(3), .TWO_STAGE(1'b1), .SINGLE_BUS(1'b1), .GROUP_EN(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .arm(arm), .probe(probe), .cfg_value(cv), .cfg_limit(cl),
      .cfg_mask(cm), .cfg_rise(cr), .cfg_fall(cf), .cfg_mode(cmode), .cfg_target(ctgt),
      .stage_hit(hit_m), .trig_pulse(tp_m), .triggered(tr_m));

   bus_trig_seq #(.PROBE_W(8), .CNT_W(0), .TWO_STAGE(1'b0), .SINGLE_BUS(1'b1), .GROUP_EN(1'b1)) dut_one (
      .clk(clk), .rst_n(rst_n), .arm(arm), .probe(probe), .cfg_value(cv), .cfg_limit(cl),
      .cfg_mask(cm), .cfg_rise(cr), .cfg_fall(cf), .cfg_mode(cmode), .cfg_target(tgt_one),
      .stage_hit(hit_1), .trig_pulse(tp_1), .triggered(tr_1));

   bus_trig_seq #(.PROBE_W(8), .CNT_W(0), .TWO_STAGE(1'b0), .SINGLE_BUS(1'b0), .GROUP_EN(1'b1)) dut_multi (
      .clk(clk), .rst_n(rst_n), .arm(arm), .probe(probe), .cfg_value(cv), .cfg_limit(cl),
      .cfg_mask(cm), .cfg_rise(cr), .cfg_fall(cf), .cfg_mode(cmode), .cfg_target(tgt_one),
      .stage_hit(hit_x), .trig_pulse(tp_x), .triggered(tr_x));

   bus_trig_seq #(.PROBE_W(8), .CNT_W(3), .TWO_STAGE(1'b1), .SINGLE_BUS(1'b1), .GROUP_EN(1'b0)) dut_off (
      .clk(clk), .rst_n(rst_n), .arm(arm), .probe(probe), .cfg_value(cv), .cfg_limit(cl),
      .cfg_mask(cm), .cfg_rise(cr), .cfg_fall(cf), .cfg_mode(cmode), .cfg_target(ctgt),
      .stage_hit(hit_o), .trig_pulse(tp_o), .triggered(tr_o));

   // reference model state
   bit       m_run, m_trig, m_pulse, m_stage;
   bit [2:0] m_cnt;
   bit       o_run, o_trig, o_pulse, x_run, x_trig, x_pulse;
   bit [7:0] prv;
   bit       pv;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
      end
   endtask

   function automatic string mode_tag(logic [2:0] md);
      if (md >= 3'd1 && md <= 3'd5) return "R3";
      if (md == 3'd6) return "R5";
      return "R2";
   endfunction

   function automatic bit cmp(bit single, logic [2:0] md, logic [7:0] p, logic [7:0] pr, bit pok,
                              logic [7:0] v, logic [7:0] l, logic [7:0] m,
                              logic [7:0] r, logic [7:0] f);
      logic [7:0] a, b, c;
      logic [2:0] k;
      bit ok;
      a = p & m; b = v & m; c = l & m;
      k = md;
      if (k == 3'd7 || (!single && k >= 3'd1 && k <= 3'd5)) k = 3'd0;
      case (k)
         3'd0: return a == b;
         3'd1: return a != b;
         3'd2: return a > b;
         3'd3: return a < b;
         3'd4: return (a >= b) && (a <= c);
         3'd5: return !((a >= b) && (a <= c));
         default: begin
            ok = 1'b1;
            for (int i = 0; i < 8; i++) begin
               if (m[i]) begin
                  if (r[i])      ok &= pok && !pr[i] && p[i];
                  else if (f[i]) ok &= pok && pr[i] && !p[i];
                  else           ok &= (p[i] == v[i]);
               end
            end
            return ok;
         end
      endcase
   endfunction

   // one clock: combinational hits checked mid-cycle, registered outputs after the edge
   task automatic step();
      bit e0, e1, oe, xe, ehit;
      @(negedge clk);
      e0 = m_run && !m_trig && cmp(1, cmode[0], probe, prv, pv, cv[0], cl[0], cm[0], cr[0], cf[0]);
      e1 = m_run && !m_trig && cmp(1, cmode[1], probe, prv, pv, cv[1], cl[1], cm[1], cr[1], cf[1]);
      oe = o_run && !o_trig && cmp(1, cmode[0], probe, prv, pv, cv[0], cl[0], cm[0], cr[0], cf[0]);
      xe = x_run && !x_trig && cmp(0, cmode[0], probe, prv, pv, cv[0], cl[0], cm[0], cr[0], cf[0]);
      chk(mode_tag(cmode[0]), hit_m[0], e0);
      chk(mode_tag(cmode[1]), hit_m[1], e1);
      chk("R7", hit_1[0], oe);
      chk("R12", hit_1[1], 0);
      chk("R4", hit_x[0], xe);
      chk("R11", {hit_o, tr_o, tp_o}, 0);
      if (arm) begin
         m_run = 1; m_trig = 0; m_pulse = 0; m_stage = 0; m_cnt = 0;
         o_run = 1; o_trig = 0; o_pulse = 0;
         x_run = 1; x_trig = 0; x_pulse = 0;
      end else begin
         m_pulse = 0; o_pulse = 0; x_pulse = 0;
         ehit = m_stage ? e1 : e0;
         if (ehit) begin
            if ({1'b0, m_cnt} + 4'd1 >= {1'b0, ctgt[m_stage]}) begin
               if (!m_stage) begin m_stage = 1; m_cnt = 0; end
               else begin m_trig = 1; m_pulse = 1; end
            end else m_cnt++;
         end
         if (oe) begin o_trig = 1; o_pulse = 1; end
         if (xe) begin x_trig = 1; x_pulse = 1; end
      end
      prv = probe;
      pv = !arm;
      @(posedge clk);
      #1;
      chk("R9", tp_m, m_pulse);
      chk("R9", tr_m, m_trig);
      chk("R7", {tp_1, tr_1}, {o_pulse, o_trig});
      chk("R4", {tp_x, tr_x}, {x_pulse, x_trig});
   endtask

   task automatic drive(logic a, logic [7:0] p);
      arm = a;
      probe = p;
      step();
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      chk("R1", {hit_m, tp_m, tr_m}, 0);
      chk("R1", {hit_1, tp_1, tr_1}, 0);
      rst_n = 1'b1;
      // matching config before any arm: nothing happens (R1)
      cm[0] = 8'hFF; cv[0] = 8'h5A; cm[1] = 8'hFF; cv[1] = 8'h33;
      ctgt[0] = 3'd3; ctgt[1] = 3'd1;
      repeat (3) drive(0, 8'h5A);
      chk("R1", tr_m, 0);

      // R6 / R8: three non-consecutive stage 0 hits, stage 1 value early is ignored
      drive(1, 8'h00);
      drive(0, 8'h33);
      drive(0, 8'h5A);
      drive(0, 8'h00);
      drive(0, 8'h5A);
      drive(0, 8'h33);
      chk("R8", tr_m, 0);
      drive(0, 8'h5A);
      chk("R6", tr_m, 0);
      drive(0, 8'h33);
      chk("R8", tr_m, 1);
      drive(0, 8'h33);
      drive(0, 8'h5A);
      chk("R9", {tp_m, tr_m}, 2'b01);

      // R10: rearm while triggered
      drive(1, 8'h00);
      chk("R10", tr_m, 0);

      // R5: rising edge on bit 0, then falling edge on bit 1
      cmode[0] = 3'd6; cm[0] = 8'h01; cr[0] = 8'h01; cf[0] = 8'h00; ctgt[0] = 3'd0;
      cmode[1] = 3'd6; cm[1] = 8'h02; cr[1] = 8'h00; cf[1] = 8'h02; ctgt[1] = 3'd0;
      drive(0, 8'h00);
      drive(1, 8'h00);
      drive(0, 8'h01);
      chk("R5", tr_m, 0);
      drive(0, 8'h00);
      drive(0, 8'h01);
      drive(0, 8'h02);
      drive(0, 8'h00);
      chk("R5", tr_m, 1);

      // R3: inclusive range
      cmode[0] = 3'd4; cm[0] = 8'hFF; cv[0] = 8'h10; cl[0] = 8'h20; cr[0] = '0;
      cmode[1] = 3'd5; cm[1] = 8'hFF; cv[1] = 8'h10; cl[1] = 8'h20; cf[1] = '0;
      drive(1, 8'h00);
      drive(0, 8'h0F);
      drive(0, 8'h20);
      drive(0, 8'h21);
      chk("R3", tr_m, 1);

      // constrained random
      for (int c = 0; c < 6000; c++) begin
         if (c % 40 == 0) begin
            for (int s = 0; s < 2; s++) begin
               cmode[s] = 3'($urandom % 8);
               cv[s] = 8'($urandom & 32'h1F);
               cl[s] = 8'($urandom & 32'h1F);
               cm[s] = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom & 32'h1F);
               cr[s] = 8'($urandom & $urandom & 32'h1F);
               cf[s] = 8'($urandom & $urandom & 32'h1F);
               ctgt[s] = 3'($urandom % 8);
            end
         end
         drive(($urandom % 24) == 0, 8'($urandom & 32'h1F));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule